// File: doc/BRIEF.md
# Radio Power-State Controller

This block holds the top-level power state of a low-power radio: OFF, ON or SLEEP. It takes decoded host commands (sleep, hard reset), the active-low chip-select line as a wake source, and a wake request from the wake-up timer. From these it decides whether the configuration RAM keeps its contents while asleep. It tells the RAM to retain through a retention-enable line. It tells the host, through a flag, whether the next restart needs the full initialisation or only the short chip-select wake sequence.

Commands arrive as a one-cycle strobe with a code. They are plain control pulses with no back-pressure: the block takes every strobe in the cycle it is presented. A command that is unknown, or that is not legal in the current state, is refused and raises a sticky error. The host clears that error with a read pulse.

Top module: `radio_pwr_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `state` is SLEEP (2), `full_init` is 1, `ret_en` is 0, `cmd_err` is 0 and `state_chg` is 0.
- R2: `state` is encoded OFF=0, ON=1, SLEEP=2, and the value 3 never appears.
- R3: A strobe with code 2 (hard reset) is accepted in every state. One cycle later `state` is SLEEP, `ret_en` is 0 and `full_init` is 1. It takes priority over any wake presented in the same cycle.
- R4: A strobe with code 1 (sleep) in OFF or ON moves to SLEEP one cycle later. `ret_en` then equals the value `retain_sel` had in the command cycle, and `full_init` equals its inverse.
- R5: A sleep strobe while in SLEEP causes no state change of its own (with no wake present, `state` stays SLEEP) and sets `cmd_err` one cycle later.
- R6: `csn` low while in SLEEP moves to OFF one cycle later. This takes priority over a timer wake in the same cycle.
- R7: `wake_req` high while in SLEEP (and `csn` high) moves to ON when `wake_to_on` is 1, otherwise to OFF. In OFF or ON, `csn` and `wake_req` have no effect on `state`.
- R8: `ret_en` is 1 only while in SLEEP and drops in the cycle `state` leaves SLEEP. `full_init` keeps the value set at the last sleep entry until the next sleep entry.
- R9: `state_chg` is 1 for exactly the one cycle in which `state` shows a new value, and 0 otherwise.
- R10: A strobe with any code other than 1 or 2 leaves `state` unchanged and sets `cmd_err` one cycle later. `cmd_err` stays set until `err_clr` is pulsed. If a new error and `err_clr` fall in the same cycle, the error wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 3 | Command code: 1 sleep, 2 hard reset, others unknown |
| retain_sel | input | 1 | Retention-enable control bit from configuration |
| csn | input | 1 | Chip-select, active low; low wakes from SLEEP |
| wake_req | input | 1 | Wake request from the wake-up timer |
| wake_to_on | input | 1 | Target of a timer wake: 1 ON, 0 OFF |
| err_clr | input | 1 | Host read pulse that clears the sticky error |
| state | output | 2 | Current state: 0 OFF, 1 ON, 2 SLEEP |
| state_chg | output | 1 | One-cycle pulse when `state` changes |
| ret_en | output | 1 | Keep configuration RAM contents |
| full_init | output | 1 | 1: full initialisation needed; 0: short wake sequence |
| cmd_err | output | 1 | Sticky refused-command flag |

## Verification
A corrupted state register shows up on `state` and `state_chg` in the very next cycle. A wrongly latched retention decision stays hidden until the sleep entry. It then appears on `ret_en` at once, and on `full_init` through the whole sleep and the wake that follows. A missing refusal of a command appears on `cmd_err` one cycle after the strobe. It stays visible until the host clears it, so every mismatch can be seen at the ports within one cycle of its cause.

// File: rtl/radio_pwr_pkg.sv
package radio_pwr_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_ON    = 2'd1,
    PS_SLEEP = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic go_sleep;
    logic hard_rst;
    logic unknown;
  } cmd_class_t;
endpackage

// File: rtl/radio_pwr_cmd_dec.sv
module radio_pwr_cmd_dec #(
  parameter int CMD_W      = 3,
  parameter int CODE_SLEEP = 1,
  parameter int CODE_HRST  = 2
) (
  input  logic                     strobe,
  input  logic [CMD_W-1:0]         code,
  output radio_pwr_pkg::cmd_class_t cls
);
  localparam logic [CMD_W-1:0] K_SLEEP = CMD_W'(CODE_SLEEP);
  localparam logic [CMD_W-1:0] K_HRST  = CMD_W'(CODE_HRST);

  always_comb begin
    cls.go_sleep = strobe && (code == K_SLEEP);
    cls.hard_rst = strobe && (code == K_HRST);
    cls.unknown  = strobe && (code != K_SLEEP) && (code != K_HRST);
  end
endmodule

// File: rtl/radio_pwr_fsm.sv
module radio_pwr_fsm
  import radio_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_class_t cls,
  input  logic       retain_sel,
  input  logic       csn,
  input  logic       wake_req,
  input  logic       wake_to_on,
  output pwr_state_e st,
  output logic       chg,
  output logic       keep,
  output logic       need_full,
  output logic       refused
);
  pwr_state_e st_n;
  logic keep_n, full_n;

  always_comb begin
    st_n   = st;
    keep_n = keep;
    full_n = need_full;
    if (cls.hard_rst) begin
      st_n   = PS_SLEEP;
      keep_n = 1'b0;
      full_n = 1'b1;
    end else begin
      unique case (st)
        PS_SLEEP: begin
          if (!csn)          st_n = PS_OFF;
          else if (wake_req) st_n = wake_to_on ? PS_ON : PS_OFF;
        end
        PS_OFF, PS_ON: begin
          if (cls.go_sleep) begin
            st_n   = PS_SLEEP;
            keep_n = retain_sel;
            full_n = !retain_sel;
          end
        end
        default: st_n = PS_SLEEP;
      endcase
    end
    if (st_n != PS_SLEEP) keep_n = 1'b0;
  end

  assign refused = cls.unknown || (cls.go_sleep && st == PS_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_SLEEP;
      keep      <= 1'b0;
      need_full <= 1'b1;
      chg       <= 1'b0;
    end else begin
      st        <= st_n;
      keep      <= keep_n;
      need_full <= full_n;
      chg       <= (st_n != st);
    end
  end
endmodule

// File: rtl/radio_pwr_err.sv
module radio_pwr_err (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/radio_pwr_ctrl.sv
module radio_pwr_ctrl #(
  parameter int CMD_W      = 3,
  parameter int CODE_SLEEP = 1,
  parameter int CODE_HRST  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             retain_sel,
  input  logic             csn,
  input  logic             wake_req,
  input  logic             wake_to_on,
  input  logic             err_clr,
  output logic [1:0]       state,
  output logic             state_chg,
  output logic             ret_en,
  output logic             full_init,
  output logic             cmd_err
);
  import radio_pwr_pkg::*;

  cmd_class_t cls;
  pwr_state_e st;
  logic       refused;

  radio_pwr_cmd_dec #(
    .CMD_W(CMD_W), .CODE_SLEEP(CODE_SLEEP), .CODE_HRST(CODE_HRST)
  ) dec_i (
    .strobe(cmd_valid), .code(cmd_code), .cls(cls)
  );

  radio_pwr_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .cls(cls), .retain_sel(retain_sel),
    .csn(csn), .wake_req(wake_req), .wake_to_on(wake_to_on),
    .st(st), .chg(state_chg), .keep(ret_en), .need_full(full_init),
    .refused(refused)
  );

  radio_pwr_err err_i (
    .clk(clk), .rst_n(rst_n), .set_i(refused), .clr_i(err_clr),
    .flag_o(cmd_err)
  );

  assign state = st;
endmodule

// File: rtl/radio_pwr_ctrl_chk.sv
module radio_pwr_ctrl_chk #(
  parameter int CMD_W      = 3,
  parameter int CODE_SLEEP = 1,
  parameter int CODE_HRST  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_code,
  input logic             csn,
  input logic             wake_req,
  input logic [1:0]       state,
  input logic             state_chg,
  input logic             ret_en,
  input logic             full_init,
  input logic             cmd_err
);
  localparam logic [CMD_W-1:0] K_SLEEP = CMD_W'(CODE_SLEEP);
  localparam logic [CMD_W-1:0] K_HRST  = CMD_W'(CODE_HRST);

  // R2
  enc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);

  // R3
  hard_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == K_HRST) |=> (state == 2'd2 && full_init && !ret_en));

  // R5
  sleep_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == K_SLEEP && state == 2'd2 && csn && !wake_req)
    |=> (state == 2'd2 && cmd_err));

  // R6
  csn_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && !csn && !(cmd_valid && cmd_code == K_HRST)) |=> state == 2'd0);

  // R8
  keep_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en |-> state == 2'd2);

  // R9
  chg_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state)) |-> state_chg);

  // R9
  chg_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg |-> (state != $past(state)));

  // R10
  unknown_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code != K_SLEEP && cmd_code != K_HRST) |=> cmd_err);
endmodule

bind radio_pwr_ctrl radio_pwr_ctrl_chk #(
  .CMD_W(CMD_W), .CODE_SLEEP(CODE_SLEEP), .CODE_HRST(CODE_HRST)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .csn(csn), .wake_req(wake_req), .state(state), .state_chg(state_chg),
  .ret_en(ret_en), .full_init(full_init), .cmd_err(cmd_err)
);

// File: tb/radio_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module radio_pwr_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic       retain_sel = 1'b0;
  logic       csn = 1'b1;
  logic       wake_req = 1'b0;
  logic       wake_to_on = 1'b0;
  logic       err_clr = 1'b0;
  logic [1:0] state;
  logic       state_chg, ret_en, full_init, cmd_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int m_st = 2;
  bit m_ret = 1'b0, m_full = 1'b1, m_err = 1'b0, m_chg = 1'b0;

  always #10 clk = ~clk;

  radio_pwr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .retain_sel(retain_sel), .csn(csn), .wake_req(wake_req),
    .wake_to_on(wake_to_on), .err_clr(err_clr), .state(state),
    .state_chg(state_chg), .ret_en(ret_en), .full_init(full_init),
    .cmd_err(cmd_err)
  );

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string event_tag(bit v, int c, bit cs, bit wr, int st);
    if (v && c == 2) return "R3";
    if (v && c == 1 && st != 2) return "R4";
    if (v && c == 1) return "R5";
    if (st == 2 && !cs) return "R6";
    if (st == 2 && wr) return "R7";
    return "R8";
  endfunction

  task automatic step(bit v, int c, bit rs, bit cs, bit wr, bit won, bit ec);
    string tag;
    int nst;
    bit nret, nfull;
    @(negedge clk);
    cmd_valid = v; cmd_code = 3'(c); retain_sel = rs; csn = cs;
    wake_req = wr; wake_to_on = won; err_clr = ec;
    tag = event_tag(v, c, cs, wr, m_st);
    nst = m_st; nret = m_ret; nfull = m_full;
    if (v && c == 2) begin
      nst = 2; nret = 1'b0; nfull = 1'b1;
    end else if (m_st == 2) begin
      if (!cs) nst = 0;
      else if (wr) nst = won ? 1 : 0;
    end else if (v && c == 1) begin
      nst = 2; nret = rs; nfull = !rs;
    end
    if (nst != 2) nret = 1'b0;
    if (v && (c == 0 || c > 2 || (c == 1 && m_st == 2))) m_err = 1'b1;
    else if (ec) m_err = 1'b0;
    m_chg = (nst != m_st);
    m_st = nst; m_ret = nret; m_full = nfull;
    @(posedge clk);
    #2;
    check(tag, "state", int'(state), m_st);
    check(tag, "ret_en", int'(ret_en), int'(m_ret));
    check(tag, "full_init", int'(full_init), int'(m_full));
    check("R9", "state_chg", int'(state_chg), int'(m_chg));
    check("R10", "cmd_err", int'(cmd_err), int'(m_err));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", "state", int'(state), 2);
    check("R1", "full_init", int'(full_init), 1);
    check("R1", "ret_en", int'(ret_en), 0);
    check("R1", "cmd_err", int'(cmd_err), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", "state after release", int'(state), 2);
    check("R1", "state_chg after release", int'(state_chg), 0);

    // R5: sleep while asleep is refused
    step(1, 1, 1, 1, 0, 0, 0);
    // R10: error clears on read pulse
    step(0, 0, 0, 1, 0, 0, 1);
    // R7: timer wake to ON
    step(0, 0, 0, 1, 1, 1, 0);
    // R7: csn and wake in ON have no effect
    step(0, 0, 0, 0, 1, 0, 0);
    // R4: retained sleep
    step(1, 1, 1, 1, 0, 0, 0);
    // R6: csn wins over timer wake
    step(0, 0, 0, 0, 1, 1, 0);
    // R8: short-wake flag holds after wake
    step(0, 0, 0, 1, 0, 0, 0);
    // R4: non-retained sleep from OFF
    step(1, 1, 0, 1, 0, 0, 0);
    // R3: hard reset beats wake in SLEEP
    step(1, 2, 1, 0, 1, 1, 0);
    // R10: unknown code in SLEEP, error set wins over clear
    step(1, 7, 0, 1, 0, 0, 1);
    step(1, 0, 0, 1, 0, 0, 0);
    // R3: hard reset from ON
    step(0, 0, 0, 1, 1, 1, 1);
    step(1, 2, 1, 1, 0, 0, 0);

    void'($urandom(32'd4242));
    for (int i = 0; i < 3000; i++) begin
      bit v, rs, cs, wr, won, ec;
      int c, pick;
      v = ($urandom % 4) == 0;
      pick = int'($urandom % 8);
      c = (pick < 3) ? 1 : (pick < 5) ? 2 : int'($urandom % 8);
      rs = $urandom % 2;
      cs = ($urandom % 10) != 0;
      wr = ($urandom % 8) == 0;
      won = $urandom % 2;
      ec = ($urandom % 10) == 0;
      step(v, c, rs, cs, wr, won, ec);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule